// File: doc/BRIEF.md
# Pipelined Integer Base-2 Logarithm

This block turns an unsigned integer into a fixed-point base-2 logarithm and takes a new operand on every clock. The result is a whole-number part and a fraction. The whole-number part is the bit index of the highest set bit of the operand. The fraction is looked up in a small table. The address of that table is the group of bits that sits just under the highest set bit, once the operand has been normalised.

The work runs in a fixed four-stage pipe:

1. Register the operand and flag a zero operand.
2. Count the leading zeros.
3. Shift the operand left so that its top bit is one, then take the table index from the bits under that top bit.
4. Read the table and register the result.

A zero operand has no logarithm. It leaves the pipe with a zero flag and a result of all zeros.

The table is loaded by the surrounding logic through a simple write port. The table has two build variants, chosen by a parameter:

- In direct mode the table holds log2(m) for a mantissa m in [1,2).
- In residual mode the table holds log2(m) − (m − 1), which lies between 0 and about 0.087. After the lookup, the dropped mantissa fraction is added back. A sum that would reach 1.0 is clamped to all ones.

Top module: `ilog2_pipe`

## Requirements
- R1: An operand of zero is returned with `out_zero` = 1 and `out_log` = 0.
- R2: Every accepted operand (`in_valid` = 1) produces exactly one `out_valid` pulse four clock edges later. Bubbles are kept in the same places.
- R3: For a nonzero operand, the top EXP_W bits of `out_log` hold the index of the operand's highest set bit. This equals IN_W − 1 minus the leading-zero count.
- R4: In direct mode, the low FRAC_W bits of `out_log` equal the table entry addressed by the ADDR_W operand bits directly below the highest set bit. The bit nearest the leading one is the index MSB. Bits missing below bit 0 read as zero.
- R5: In residual mode, the fraction equals the table entry plus the index shifted left by FRAC_W − ADDR_W. The sum saturates at 2^FRAC_W − 1.
- R6: A write of (`tbl_addr`, `tbl_wdata`) with `tbl_we` = 1 replaces that entry for all later lookups.
- R7: Operands may arrive on consecutive cycles, and each yields its own result in order.
- R8: While `rst_n` is low, `out_valid`, `out_zero` and `out_log` are all zero.
- R9: Suppose the table is loaded with rounded log2 values (direct) or rounded residuals (residual), scaled by 2^FRAC_W. Then the fraction is within one LSB of log2(1 + index/2^ADDR_W)·2^FRAC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | IN_W | Unsigned operand |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | ADDR_W | Table write index |
| tbl_wdata | input | FRAC_W | Table write value |
| out_valid | output | 1 | Result strobe |
| out_zero | output | 1 | Operand was zero |
| out_log | output | EXP_W+FRAC_W | {integer part, fraction} |

## Verification
The hardest case to reach is the clamp in residual mode. A correctly loaded table never makes the sum reach 1.0, so ordinary operands can never trigger it. The stimulus therefore lets the pipe drain, then rewrites the top table entry to all ones through the write port. It then sends an operand whose bits under the leading one are all ones, which drives the clamp and also shows that the rewrite took effect. Zero operands and idle cycles are mixed into a long back-to-back stream, so that the zero flag and the valid timing are tested while neighbouring stages hold real data.

// File: rtl/ilog2_pkg.sv
package ilog2_pkg;
   typedef enum logic {
      TBL_DIRECT   = 1'b0,
      TBL_RESIDUAL = 1'b1
   } tbl_mode_e;
endpackage

// File: rtl/ilog2_lzc.sv
module ilog2_lzc #(
   parameter int IN_W  = 16,
   parameter int CNT_W = 4
) (
   input  logic [IN_W-1:0]  din,
   output logic [CNT_W-1:0] cnt
);
   // ascending scan: the highest set bit is assigned last and wins
   always_comb begin
      cnt = '0;
      for (int i = 0; i < IN_W; i++) begin
         if (din[i]) cnt = CNT_W'(IN_W - 1 - i);
      end
   end
endmodule

// File: rtl/ilog2_norm.sv
module ilog2_norm #(
   parameter int IN_W   = 16,
   parameter int CNT_W  = 4,
   parameter int ADDR_W = 6
) (
   input  logic [IN_W-1:0]   din,
   input  logic [CNT_W-1:0]  shamt,
   output logic              lead,
   output logic [ADDR_W-1:0] idx
);
   logic [IN_W-1:0] shifted;

   assign shifted = din << shamt;
   assign lead    = shifted[IN_W-1];
   assign idx     = shifted[IN_W-2 -: ADDR_W];
endmodule

// File: rtl/ilog2_ftab.sv
module ilog2_ftab
   import ilog2_pkg::*;
#(
   parameter int        ADDR_W = 6,
   parameter int        FRAC_W = 10,
   parameter tbl_mode_e MODE   = TBL_DIRECT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [FRAC_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [FRAC_W-1:0] frac
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAD   = FRAC_W - ADDR_W;

   logic [FRAC_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (MODE == TBL_RESIDUAL) begin : g_residual
         logic [FRAC_W:0] sum;
         logic [FRAC_W:0] lin;
         assign lin  = (FRAC_W+1)'(raddr) << PAD;
         assign sum  = {1'b0, mem[raddr]} + lin;
         assign frac = sum[FRAC_W] ? '1 : sum[FRAC_W-1:0];

         // R5: the restored linear term is never lost through wrap-around
         p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            {1'b0, frac} >= lin);
      end else begin : g_direct
         assign frac = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/ilog2_pipe.sv
module ilog2_pipe
   import ilog2_pkg::*;
#(
   parameter int        IN_W   = 16,
   parameter int        FRAC_W = 10,
   parameter int        ADDR_W = 6,
   parameter tbl_mode_e MODE   = TBL_DIRECT
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [IN_W-1:0]               in_data,
   input  logic                          tbl_we,
   input  logic [ADDR_W-1:0]             tbl_addr,
   input  logic [FRAC_W-1:0]             tbl_wdata,
   output logic                          out_valid,
   output logic                          out_zero,
   output logic [$clog2(IN_W)+FRAC_W-1:0] out_log
);
   localparam int EXP_W = $clog2(IN_W);
   localparam int OUT_W = EXP_W + FRAC_W;

   generate
      if (IN_W < 2) begin : g_bad_in
         $error("IN_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > IN_W - 1) begin : g_bad_addr
         $error("ADDR_W must lie in 1..IN_W-1");
      end
      if (ADDR_W > FRAC_W) begin : g_bad_frac
         $error("ADDR_W must not exceed FRAC_W");
      end
   endgenerate

   // stage 1: capture and zero detect
   logic            s1_v, s1_z;
   logic [IN_W-1:0] s1_d;
   // stage 2: leading-zero count
   logic             s2_v, s2_z;
   logic [IN_W-1:0]  s2_d;
   logic [EXP_W-1:0] s2_lz;
   // stage 3: normalised index and integer part
   logic              s3_v, s3_z, s3_lead;
   logic [EXP_W-1:0]  s3_exp;
   logic [ADDR_W-1:0] s3_idx;

   logic [EXP_W-1:0]  lz_c;
   logic              lead_c;
   logic [ADDR_W-1:0] idx_c;
   logic [FRAC_W-1:0] frac_c;

   ilog2_lzc #(.IN_W(IN_W), .CNT_W(EXP_W)) u_lzc (
      .din (s1_d),
      .cnt (lz_c)
   );

   ilog2_norm #(.IN_W(IN_W), .CNT_W(EXP_W), .ADDR_W(ADDR_W)) u_norm (
      .din   (s2_d),
      .shamt (s2_lz),
      .lead  (lead_c),
      .idx   (idx_c)
   );

   ilog2_ftab #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .MODE(MODE)) u_tab (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (s3_idx),
      .frac  (frac_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_z <= 1'b0; s1_d <= '0;
         s2_v <= 1'b0; s2_z <= 1'b0; s2_d <= '0; s2_lz <= '0;
         s3_v <= 1'b0; s3_z <= 1'b0; s3_lead <= 1'b0;
         s3_exp <= '0; s3_idx <= '0;
         out_valid <= 1'b0; out_zero <= 1'b0; out_log <= '0;
      end else begin
         s1_v      <= in_valid;
         s1_z      <= (in_data == '0);
         s1_d      <= in_data;
         s2_v      <= s1_v;
         s2_z      <= s1_z;
         s2_d      <= s1_d;
         s2_lz     <= lz_c;
         s3_v      <= s2_v;
         s3_z      <= s2_z;
         s3_lead   <= lead_c;
         s3_exp    <= EXP_W'(IN_W - 1) - s2_lz;
         s3_idx    <= idx_c;
         out_valid <= s3_v;
         out_zero  <= s3_v & s3_z;
         out_log   <= (s3_v && !s3_z) ? {s3_exp, frac_c} : '0;
      end
   end

   // cycles since reset, saturating, so history checks never reach into reset
   logic [2:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 3'd4) age <= age + 3'd1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

   p_zero_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4 && $past(in_valid, 4) && $past(in_data, 4) == '0) |-> (out_valid && out_zero));

   p_zero_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_zero |-> (out_log == '0));

   p_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4 && $past(in_valid, 4) && $past(in_data, 4) != '0)
      |-> (($past(in_data, 4) >> out_log[OUT_W-1 -: EXP_W]) == IN_W'(1)));

   p_norm_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_v && !s3_z) |-> s3_lead);

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_zero && out_log == '0));
endmodule

// File: tb/sim_ilog2_pipe.sv
module sim_ilog2_pipe;
   import ilog2_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int IN_W   = 16;
   localparam int FRAC_W = 10;
   localparam int ADDR_W = 6;
   localparam int EXP_W  = 4;
   localparam int OUT_W  = EXP_W + FRAC_W;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int FMAX   = (1 << FRAC_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] in_data = '0;
   logic tbl_we = 1'b0;
   logic [ADDR_W-1:0] tbl_addr = '0;
   logic [FRAC_W-1:0] wd_d = '0, wd_r = '0;
   logic ov0, oz0, ov1, oz1;
   logic [OUT_W-1:0] ol0, ol1;

   always #(CLK_PERIOD/2) clk = ~clk;

   ilog2_pipe #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .MODE(TBL_DIRECT)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(wd_d),
      .out_valid(ov0), .out_zero(oz0), .out_log(ol0));

   ilog2_pipe #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .MODE(TBL_RESIDUAL)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(wd_r),
      .out_valid(ov1), .out_zero(oz1), .out_log(ol1));

   typedef struct {
      bit  z;
      int  e;
      int  fd;
      int  fr;
      real ref_f;
      bit  acc;
   } item_t;

   item_t q[$];
   int tbl_d [DEPTH];
   int tbl_r [DEPTH];
   int n_chk = 0, n_fail = 0, n_push = 0, n_pop = 0;
   bit acc_on = 1'b1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic push(input int x);
      item_t it;
      int p, nrm, a, s;
      real m;
      it.z = (x == 0);
      p = 0;
      for (int i = 0; i < IN_W; i++) if (x[i]) p = i;
      nrm = (x << (IN_W - 1 - p)) & ((1 << IN_W) - 1);
      a = (nrm >> (IN_W - 1 - ADDR_W)) & (DEPTH - 1);
      it.e  = p;
      it.fd = tbl_d[a];
      s = tbl_r[a] + (a << (FRAC_W - ADDR_W));
      it.fr = (s > FMAX) ? FMAX : s;
      m = 1.0 + real'(a) / real'(DEPTH);
      it.ref_f = $ln(m) / $ln(2.0) * real'(1 << FRAC_W);
      it.acc = acc_on;
      q.push_back(it);
      n_push++;
   endtask

   task automatic drive(input int x, input bit v);
      @(negedge clk);
      in_valid = v;
      in_data  = IN_W'(x);
      if (v) push(x);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 1'b0);
   endtask

   task automatic twrite(input int a, input int vd, input int vr);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = ADDR_W'(a);
      wd_d = FRAC_W'(vd); wd_r = FRAC_W'(vr);
      tbl_d[a] = vd; tbl_r[a] = vr;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && ov0) begin
         if (q.size() == 0) begin
            check(1'b0, "R7 unexpected result", 1, 0);
         end else begin
            item_t it;
            int f0, f1;
            it = q.pop_front();
            n_pop++;
            check(ov1 == 1'b1, "R2 both pipes aligned", int'(ov1), 1);
            f0 = int'(ol0[FRAC_W-1:0]);
            f1 = int'(ol1[FRAC_W-1:0]);
            if (it.z) begin
               check(oz0 && ol0 == '0, "R1 zero direct", int'(ol0), 0);
               check(oz1 && ol1 == '0, "R1 zero residual", int'(ol1), 0);
            end else begin
               check(!oz0 && !oz1, "R1 nonzero flag", int'(oz0 | oz1), 0);
               check(int'(ol0[OUT_W-1 -: EXP_W]) == it.e, "R3 integer direct",
                     int'(ol0[OUT_W-1 -: EXP_W]), it.e);
               check(int'(ol1[OUT_W-1 -: EXP_W]) == it.e, "R3 integer residual",
                     int'(ol1[OUT_W-1 -: EXP_W]), it.e);
               check(f0 == it.fd, "R4 direct fraction", f0, it.fd);
               check(f1 == it.fr, "R5 residual fraction", f1, it.fr);
               if (it.acc) begin
                  real d0, d1;
                  d0 = real'(f0) - it.ref_f;
                  d1 = real'(f1) - it.ref_f;
                  check(d0 <= 1.0 && d0 >= -1.0, "R9 direct accuracy", f0, $rtoi(it.ref_f + 0.5));
                  check(d1 <= 1.0 && d1 >= -1.0, "R9 residual accuracy", f1, $rtoi(it.ref_f + 0.5));
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(!ov0 && !oz0 && ol0 == '0 && !ov1 && !oz1 && ol1 == '0,
            "R8 reset outputs", int'(ov0 | ov1 | oz0 | oz1), 0);
      @(negedge clk) rst_n = 1'b1;

      // load tables with rounded values (R6 write port)
      for (int a = 0; a < DEPTH; a++) begin
         real m, l;
         m = 1.0 + real'(a) / real'(DEPTH);
         l = $ln(m) / $ln(2.0);
         twrite(a, $rtoi(l * real'(1 << FRAC_W) + 0.5),
                   $rtoi((l - (m - 1.0)) * real'(1 << FRAC_W) + 0.5));
      end
      idle(2);

      // R2: latency of a single operand
      drive(1000, 1'b1);
      @(negedge clk) in_valid = 1'b0;
      lat = 1;
      for (int i = 2; i < 10; i++) begin
         if (ov0) break;
         @(negedge clk);
         lat = i;
      end
      check(lat == 4, "R2 latency", lat, 4);
      idle(4);

      // directed back-to-back patterns (R7)
      drive(0, 1'b1);
      drive(1, 1'b1);
      drive(2, 1'b1);
      drive(3, 1'b1);
      for (int i = 0; i < IN_W; i++) drive(1 << i, 1'b1);
      drive(16'hFFFF, 1'b1);
      drive(16'h8001, 1'b1);
      drive(0, 1'b1);
      drive(16'h00FF, 1'b1);
      drive(16'h0155, 1'b1);
      idle(6);

      // random stream with zeros and bubbles
      for (int i = 0; i < 400; i++) begin
         int r, x;
         r = int'($urandom_range(0, 15));
         x = int'($urandom_range(0, 65535)) >> $urandom_range(0, 15);
         if (r == 0) drive(0, 1'b0);
         else if (r == 1) drive(0, 1'b1);
         else drive(x, 1'b1);
      end
      idle(6);

      // R6 rewrite and R5 clamp: top entry forced high
      acc_on = 1'b0;
      twrite(DEPTH - 1, 5, FMAX);
      drive(16'hFFFF, 1'b1);   // index 63, residual sum overflows -> clamp
      drive(16'h007F, 1'b1);   // index 63 at a lower exponent
      idle(6);

      check(q.size() == 0 && n_pop == n_push, "R7 every operand answered", n_pop, n_push);
      summary();
      $finish;
   end
endmodule